// File: doc/BRIEF.md
# Operating Mode Register Controller

This block holds the processor's 16-bit operating mode register. Software writes it through a simple write strobe and reads it back at once, with every unused bit forced to zero. The two lowest bits choose one of four chip operating modes. Six further flag bits (nested looping, condition codes, stop delay, rounding, saturation, external data memory) are stored and exposed as plain outputs for other units.

A write does not reach the mode and flag outputs straight away. The block keeps a delayed copy of the register, and that copy drives all decoded outputs. The copy is refreshed only on the first instruction-advance pulse that comes after the write edge. The pending write therefore takes effect one instruction cycle after the instruction that made it.

From the active mode the block derives the reset vector, the boot ROM enable and the access policy for internal program RAM. A program-memory router applies that policy to each access. It steers the access to the boot ROM, the internal RAM or the external bus with one-hot selects. It raises a blocked flag when a read aims at internal RAM while a bootstrap mode is active.

Top module: `omr_ctrl`

## Requirements
- R1: After reset, rd_data is 0x0000, mode_o is 2'b00, every flag output is 0 and reset_vec is 0x0000.
- R2: Only bits 15, 8, 6, 5, 4, 3, 1 and 0 are stored (mask 0x817B). All other bits always read as 0, and writing 1 to them changes neither rd_data nor any output.
- R3: rd_data shows the masked written value in the cycle after the write edge, even before the delayed copy updates.
- R4: mode_o, the flags and every decoded output stay at their old values after a write. They change on the first clock edge that has instr_adv high and follows the write edge. A write edge that itself has instr_adv high does not count.
- R5: The flag outputs follow the active copy: flag_nl=bit 15, flag_cc=bit 8, flag_sd=bit 6, flag_rnd=bit 5, flag_sat=bit 4, flag_xext=bit 3, and mode_o={bit 1, bit 0}.
- R6: In modes 2'b00 (boot over external bus) and 2'b01 (boot from peripheral), reset_vec is 0x0000 and boot_rom_en is 1.
- R7: In both bootstrap modes, internal program RAM is write-only. pram_rd_ok=0 and pram_wr_ok=1. A write inside the RAM window selects sel_pram. A read inside the RAM window but outside the boot ROM window raises rd_blocked with no select active.
- R8: In mode 2'b10 (normal expanded), reset_vec is 0xE000 and boot_rom_en is 0. pram_rd_ok and pram_wr_ok are both 1. Reads and writes inside the RAM window select sel_pram, and other addresses select sel_ext.
- R9: In mode 2'b11 (development), reset_vec is 0x0000 and boot_rom_en is 0. Internal RAM is disabled (pram_rd_ok=pram_wr_ok=0), and every access selects sel_ext.
- R10: sel_brom, sel_pram and sel_ext are never active together. All of them and rd_blocked are 0 when acc_vld is 0.
- R11: In a bootstrap mode, a read inside the boot ROM window (defaults 0x0000 to 0x01FF) selects sel_brom. An address outside the RAM window (default 0x0000 to 0x0FFF) selects sel_ext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_adv | input | 1 | One pulse per completed instruction cycle |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Register read value, unused bits zero |
| mode_o | output | 2 | Active operating mode |
| flag_nl | output | 1 | Active nested-looping flag |
| flag_cc | output | 1 | Active condition-code flag |
| flag_sd | output | 1 | Active stop-delay flag |
| flag_rnd | output | 1 | Active rounding flag |
| flag_sat | output | 1 | Active saturation flag |
| flag_xext | output | 1 | Active external data memory flag |
| reset_vec | output | 16 | Reset vector for the active mode |
| boot_rom_en | output | 1 | Boot ROM is mapped |
| pram_rd_ok | output | 1 | Internal program RAM may be read |
| pram_wr_ok | output | 1 | Internal program RAM may be written |
| acc_vld | input | 1 | Program memory access valid |
| acc_wr | input | 1 | Access is a write (0 = read/fetch) |
| acc_addr | input | 16 | Program memory address |
| sel_brom | output | 1 | Access routed to boot ROM |
| sel_pram | output | 1 | Access routed to internal RAM |
| sel_ext | output | 1 | Access routed to external bus |
| rd_blocked | output | 1 | Read of internal RAM refused in bootstrap mode |

## Verification
The bench drives each of the four modes in turn. In each mode it issues reads and writes at three kinds of address: one in the boot ROM window, one in the RAM window but outside the boot ROM, and one outside both windows. This separates the modes by their routing and not only by their reset vector. The two bootstrap modes show the same routing, so checks across both confirm that the low mode bit does not leak into the memory map.

The delay is exercised in three ways:
- holding instr_adv low for several cycles after a write, to show the outputs stay put;
- writing during a cycle with instr_adv already high, to show that edge does not count;
- writing again before the first write was applied, to show only the latest value lands.

All-ones and alternating patterns separate the stored bits from the unused ones.

// File: rtl/omr_pkg.sv
package omr_pkg;

  localparam int unsigned OMR_W = 16;
  localparam logic [OMR_W-1:0] OMR_KEEP = 16'h817B;

  localparam int unsigned POS_NL  = 15;
  localparam int unsigned POS_CC  = 8;
  localparam int unsigned POS_SD  = 6;
  localparam int unsigned POS_RND = 5;
  localparam int unsigned POS_SAT = 4;
  localparam int unsigned POS_XEX = 3;

  typedef enum logic [1:0] {
    MODE_BOOT_BUS  = 2'b00,
    MODE_BOOT_PERI = 2'b01,
    MODE_NORMAL    = 2'b10,
    MODE_DEVEL     = 2'b11
  } op_mode_e;

  function automatic logic [OMR_W-1:0] keep_bits(input logic [OMR_W-1:0] v);
    return v & OMR_KEEP;
  endfunction

  function automatic logic is_boot(input op_mode_e m);
    return (m == MODE_BOOT_BUS) || (m == MODE_BOOT_PERI);
  endfunction

  function automatic logic [15:0] vector_of(input op_mode_e m);
    return (m == MODE_NORMAL) ? 16'hE000 : 16'h0000;
  endfunction

  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] base,
                                     input logic [31:0] words);
    return (a >= base) && (a < base + words);
  endfunction

endpackage

// File: rtl/omr_arch_reg.sv
module omr_arch_reg
  import omr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OMR_W-1:0] wr_data,
  output logic [OMR_W-1:0] arch_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     arch_q <= '0;
    else if (wr_en) arch_q <= keep_bits(wr_data);
  end

endmodule

// File: rtl/omr_delay_stage.sv
module omr_delay_stage
  import omr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             instr_adv,
  input  logic [OMR_W-1:0] arch_q,
  output logic [OMR_W-1:0] act_q,
  output logic             pend_q
);

  logic apply_evt;
  assign apply_evt = pend_q && instr_adv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (apply_evt) act_q <= arch_q;
      if (wr_en)          pend_q <= 1'b1;
      else if (instr_adv) pend_q <= 1'b0;
    end
  end

  assert_write_not_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pend_q) |=> $stable(act_q));
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_adv |=> $stable(act_q));

endmodule

// File: rtl/omr_mode_map.sv
module omr_mode_map
  import omr_pkg::*;
(
  input  op_mode_e    mode,
  output logic [15:0] reset_vec,
  output logic        boot_rom_en,
  output logic        pram_rd_ok,
  output logic        pram_wr_ok
);

  always_comb begin
    reset_vec   = vector_of(mode);
    boot_rom_en = is_boot(mode);
    pram_rd_ok  = (mode == MODE_NORMAL);
    pram_wr_ok  = (mode != MODE_DEVEL);
  end

endmodule

// File: rtl/omr_pmem_route.sv
module omr_pmem_route
  import omr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PRAM_BASE  = 0,
  parameter int unsigned PRAM_WORDS = 4096,
  parameter int unsigned BROM_BASE  = 0,
  parameter int unsigned BROM_WORDS = 512
) (
  input  op_mode_e          mode,
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              sel_brom,
  output logic              sel_pram,
  output logic              sel_ext,
  output logic              rd_blocked
);

  localparam int unsigned PAD = 32 - ADDR_W;

  logic [31:0] addr_w;
  logic        hit_pram, hit_brom;

  assign addr_w   = {{PAD{1'b0}}, acc_addr};
  assign hit_pram = in_window(addr_w, PRAM_BASE, PRAM_WORDS);
  assign hit_brom = in_window(addr_w, BROM_BASE, BROM_WORDS);

  always_comb begin
    sel_brom   = 1'b0;
    sel_pram   = 1'b0;
    sel_ext    = 1'b0;
    rd_blocked = 1'b0;
    if (acc_vld) begin
      unique case (mode)
        MODE_BOOT_BUS, MODE_BOOT_PERI: begin
          if (acc_wr) begin
            if (hit_pram) sel_pram = 1'b1;
            else          sel_ext  = 1'b1;
          end else if (hit_brom) sel_brom   = 1'b1;
          else if (hit_pram)     rd_blocked = 1'b1;
          else                   sel_ext    = 1'b1;
        end
        MODE_NORMAL: begin
          if (hit_pram) sel_pram = 1'b1;
          else          sel_ext  = 1'b1;
        end
        default: sel_ext = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/omr_ctrl.sv
module omr_ctrl
  import omr_pkg::*;
#(
  parameter int unsigned PRAM_BASE  = 0,
  parameter int unsigned PRAM_WORDS = 4096,
  parameter int unsigned BROM_BASE  = 0,
  parameter int unsigned BROM_WORDS = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instr_adv,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic [1:0]  mode_o,
  output logic        flag_nl,
  output logic        flag_cc,
  output logic        flag_sd,
  output logic        flag_rnd,
  output logic        flag_sat,
  output logic        flag_xext,
  output logic [15:0] reset_vec,
  output logic        boot_rom_en,
  output logic        pram_rd_ok,
  output logic        pram_wr_ok,
  input  logic        acc_vld,
  input  logic        acc_wr,
  input  logic [15:0] acc_addr,
  output logic        sel_brom,
  output logic        sel_pram,
  output logic        sel_ext,
  output logic        rd_blocked
);

  logic [OMR_W-1:0] arch_q, act_q;
  logic             pend_q;
  op_mode_e         act_mode;

  omr_arch_reg u_arch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .arch_q(arch_q)
  );

  omr_delay_stage u_delay (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .instr_adv(instr_adv),
    .arch_q(arch_q), .act_q(act_q), .pend_q(pend_q)
  );

  assign act_mode  = op_mode_e'(act_q[1:0]);
  assign rd_data   = arch_q;
  assign mode_o    = act_q[1:0];
  assign flag_nl   = act_q[POS_NL];
  assign flag_cc   = act_q[POS_CC];
  assign flag_sd   = act_q[POS_SD];
  assign flag_rnd  = act_q[POS_RND];
  assign flag_sat  = act_q[POS_SAT];
  assign flag_xext = act_q[POS_XEX];

  omr_mode_map u_map (
    .mode(act_mode), .reset_vec(reset_vec), .boot_rom_en(boot_rom_en),
    .pram_rd_ok(pram_rd_ok), .pram_wr_ok(pram_wr_ok)
  );

  omr_pmem_route #(
    .ADDR_W(16), .PRAM_BASE(PRAM_BASE), .PRAM_WORDS(PRAM_WORDS),
    .BROM_BASE(BROM_BASE), .BROM_WORDS(BROM_WORDS)
  ) u_route (
    .mode(act_mode), .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .sel_brom(sel_brom), .sel_pram(sel_pram), .sel_ext(sel_ext),
    .rd_blocked(rd_blocked)
  );

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~OMR_KEEP) == '0);
  assert_read_now_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == (($past(wr_data)) & OMR_KEEP));
  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_brom, sel_pram, sel_ext, rd_blocked}));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |-> !(sel_brom || sel_pram || sel_ext || rd_blocked));
  assert_boot_no_ramrd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_rom_en && acc_vld && !acc_wr) |-> !sel_pram);
  assert_devel_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11 && acc_vld) |-> sel_ext);
  assert_normal_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10) |-> (reset_vec == 16'hE000 && !boot_rom_en));

endmodule

// File: tb/test_omr_ctrl.sv
module test_omr_ctrl;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, instr_adv = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data, reset_vec, acc_addr = '0;
  logic [1:0]  mode_o;
  logic flag_nl, flag_cc, flag_sd, flag_rnd, flag_sat, flag_xext;
  logic boot_rom_en, pram_rd_ok, pram_wr_ok;
  logic acc_vld = 1'b0, acc_wr = 1'b0;
  logic sel_brom, sel_pram, sel_ext, rd_blocked;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  omr_ctrl i_omr_ctrl (
    .clk(clk), .rst_n(rst_n), .instr_adv(instr_adv), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .mode_o(mode_o),
    .flag_nl(flag_nl), .flag_cc(flag_cc), .flag_sd(flag_sd),
    .flag_rnd(flag_rnd), .flag_sat(flag_sat), .flag_xext(flag_xext),
    .reset_vec(reset_vec), .boot_rom_en(boot_rom_en),
    .pram_rd_ok(pram_rd_ok), .pram_wr_ok(pram_wr_ok),
    .acc_vld(acc_vld), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .sel_brom(sel_brom), .sel_pram(sel_pram), .sel_ext(sel_ext),
    .rd_blocked(rd_blocked)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one clock edge; inputs change on the falling edge, sampling 1 unit later
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic do_write(input logic [15:0] v, input logic adv);
    wr_en = 1'b1; wr_data = v; instr_adv = adv;
    step();
    wr_en = 1'b0; instr_adv = 1'b0;
  endtask

  task automatic advance();
    instr_adv = 1'b1;
    step();
    instr_adv = 1'b0;
  endtask

  function automatic logic [2:0] route(input logic [1:0] m, input logic wr,
                                       input logic [15:0] a);
    // {brom, pram, ext}; blocked when all zero with a valid access
    logic in_ram, in_rom;
    in_ram = a < 16'h1000;
    in_rom = a < 16'h0200;
    if (m == 2'b11) return 3'b001;
    if (m == 2'b10) return in_ram ? 3'b010 : 3'b001;
    if (wr) return in_ram ? 3'b010 : 3'b001;
    if (in_rom) return 3'b100;
    return in_ram ? 3'b000 : 3'b001;
  endfunction

  task automatic probe(input string req, input logic wr, input logic [15:0] a);
    logic [2:0] e;
    e = route(mode_o, wr, a);
    acc_vld = 1'b1; acc_wr = wr; acc_addr = a;
    #1;
    check(req, "route", {29'd0, sel_brom, sel_pram, sel_ext}, {29'd0, e});
    check(req, "rd_blocked", {31'd0, rd_blocked}, {31'd0, e == 3'b000});
    acc_vld = 1'b0;
    #1;
  endtask

  task automatic set_mode(input logic [1:0] m);
    do_write({14'd0, m}, 1'b0);
    advance();
  endtask

  task automatic t_reset();
    check("R1", "rd_data", {16'd0, rd_data}, 0);
    check("R1", "mode", {30'd0, mode_o}, 0);
    check("R1", "flags", {26'd0, flag_nl, flag_cc, flag_sd, flag_rnd, flag_sat, flag_xext}, 0);
    check("R1", "reset_vec", {16'd0, reset_vec}, 0);
  endtask

  task automatic t_reserved();
    do_write(16'hFFFF, 1'b0);
    check("R2", "all ones read", {16'd0, rd_data}, 32'h817B);
    advance();
    check("R5", "flags after ones", {26'd0, flag_nl, flag_cc, flag_sd, flag_rnd, flag_sat, flag_xext}, 6'h3F);
    do_write(16'h7E84, 1'b0);
    check("R2", "reserved only read", {16'd0, rd_data}, 0);
    advance();
    check("R2", "reserved only flags", {24'd0, flag_nl, flag_cc, flag_sd, flag_rnd, flag_sat, flag_xext, mode_o}, 0);
  endtask

  task automatic t_delay();
    do_write(16'h0102, 1'b0);
    check("R3", "immediate read", {16'd0, rd_data}, 32'h0102);
    check("R4", "mode held after write", {30'd0, mode_o}, 0);
    step(); step(); step();
    check("R4", "mode held idle", {30'd0, mode_o}, 0);
    check("R4", "vec held idle", {16'd0, reset_vec}, 0);
    advance();
    check("R4", "mode applied", {30'd0, mode_o}, 2);
    check("R5", "cc flag", {31'd0, flag_cc}, 1);
    do_write(16'h0020, 1'b1);
    check("R4", "write edge with adv", {30'd0, mode_o}, 2);
    advance();
    check("R4", "applied next adv", {30'd0, mode_o}, 0);
    check("R5", "rnd flag", {31'd0, flag_rnd}, 1);
    do_write(16'h0003, 1'b0);
    do_write(16'h8001, 1'b0);
    advance();
    check("R4", "latest write wins", {30'd0, mode_o}, 1);
    check("R5", "nl flag", {31'd0, flag_nl}, 1);
  endtask

  task automatic t_boot(input logic [1:0] m, input string tag);
    set_mode(m);
    check("R6", {tag, " vec"}, {16'd0, reset_vec}, 0);
    check("R6", {tag, " boot rom"}, {31'd0, boot_rom_en}, 1);
    check("R7", {tag, " ram policy"}, {30'd0, pram_rd_ok, pram_wr_ok}, 2'b01);
    probe("R11", 1'b0, 16'h0010);
    probe("R7", 1'b0, 16'h0800);
    probe("R7", 1'b1, 16'h0800);
    probe("R11", 1'b0, 16'h2000);
  endtask

  task automatic t_normal();
    set_mode(2'b10);
    check("R8", "vec", {16'd0, reset_vec}, 32'hE000);
    check("R8", "boot rom", {31'd0, boot_rom_en}, 0);
    check("R8", "ram policy", {30'd0, pram_rd_ok, pram_wr_ok}, 2'b11);
    probe("R8", 1'b0, 16'h0010);
    probe("R8", 1'b1, 16'h0FFF);
    probe("R8", 1'b0, 16'h1000);
  endtask

  task automatic t_devel();
    set_mode(2'b11);
    check("R9", "vec", {16'd0, reset_vec}, 0);
    check("R9", "ram policy", {29'd0, boot_rom_en, pram_rd_ok, pram_wr_ok}, 0);
    probe("R9", 1'b0, 16'h0010);
    probe("R9", 1'b1, 16'h0800);
  endtask

  task automatic t_idle();
    set_mode(2'b00);
    acc_vld = 1'b0; acc_wr = 1'b0; acc_addr = 16'h0800;
    #1;
    check("R10", "idle selects", {28'd0, sel_brom, sel_pram, sel_ext, rd_blocked}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_reserved();
    t_delay();
    t_boot(2'b00, "bus boot");
    t_boot(2'b01, "peri boot");
    t_normal();
    t_devel();
    t_idle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule